// File: doc/BRIEF.md
# Low-Power Weighted Pseudo-Random Scan Stimulus Generator

This block produces scan-chain stimulus in which the amount of bit toggling is under control. A 32-bit maximal-length shift-register generator supplies pseudo-random bits to a bank of hold stages, one per generator bit. A per-stage enable mask decides which stages copy fresh generator data each clock and which freeze their previous bit. A three-input XOR network combines the stage outputs into 16 scan-chain inputs. A chain that is fed only by frozen stages sees a constant value, so it does not toggle and draws little power while it is shifted.

The enable mask is reloaded at every pattern boundary from a side shift register. That register takes in one weighted random bit per clock. The weighting comes from a 4-bit switching code. Each code bit enables one AND term of generator bits, and the four terms have one-probabilities of 1/2, 1/4, 1/8 and 1/16. The enabled terms are ORed, so the code sets roughly what fraction of stages toggle during the next pattern. The all-zero code turns the power-saving function off: every stage then follows the generator.

Top module: `lpwpg_top`

## Requirements
- R1: While `rst` is high at a clock edge, the generator loads `seed`, every hold stage clears to 0, the enable mask is set to all ones and the side register clears to 0. During reset `scan_in` reads all zeros.
- R2: On each clock edge outside reset, the generator state s advances to (s >> 1) XOR (s[0] ? 32'h80200003 : 0), which is a right-shifting Galois form of x^32+x^22+x^2+x+1.
- R3: Scan output j (0..15) is the XOR of hold stages j, j+16 and (7*j+3) mod 32. These are three distinct stages for every j.
- R4: The weighted bit is computed from the current generator state s as (code[3] & s[0]) | (code[2] & s[1] & s[2]) | (code[1] & s[3] & s[4] & s[5]) | (code[0] & s[6] & s[7] & s[8] & s[9]).
- R5: On every edge outside reset, the side register shifts left by one place and the weighted bit enters at bit 0.
- R6: When `pat_start` is high at an edge, the enable mask takes the side register's value from before that edge. Otherwise the mask keeps its value.
- R7: On each edge, a hold stage i whose mask bit is 1 captures generator bit i. A stage whose mask bit is 0 keeps its bit.
- R8: While `sw_code` is 4'b0000, every hold stage captures its generator bit, whatever the mask holds.
- R9: A `seed` of zero at reset loads 32'h00000001 instead, so the generator never locks at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_start | input | 1 | Pattern boundary: reload the enable mask |
| sw_code | input | 4 | Switching code setting the toggle weighting |
| seed | input | 32 | Generator seed loaded in reset |
| scan_in | output | 16 | Stimulus to the scan-chain inputs |

## Verification
The bench sweeps all sixteen switching codes over several 32-cycle patterns. It also inserts pattern starts at irregular spacing, so that the mask is sometimes reloaded from a side register that is only partly refreshed. A design that loaded the mask from the register after its shift, or that reloaded on every edge, would hold the wrong stages. A swapped weight term would change which stages freeze under the single-bit codes. The all-zero code is tested with a sparse mask already in place: a design that ignored the bypass would leave chains frozen. A zero seed is tested, because an unguarded generator would stay at zero and every output would sit at 0.

// File: rtl/lpwpg_pkg.sv
package lpwpg_pkg;

    localparam int GEN_W     = 32;
    localparam int N_CHAINS  = 16;
    localparam int CODE_W    = 4;
    localparam int WSRC_W    = 10;
    localparam logic [GEN_W-1:0] GEN_MASK = 32'h8020_0003;

    typedef logic [GEN_W-1:0]  gen_vec_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic half;
        logic quarter;
        logic eighth;
        logic sixteenth;
    } wterm_t;

    // one step of the right-shifting Galois generator
    function automatic gen_vec_t gen_step(input gen_vec_t s);
        gen_vec_t nxt;
        nxt = {1'b0, s[GEN_W-1:1]};
        if (s[0]) nxt = nxt ^ GEN_MASK;
        return nxt;
    endfunction

    // a zero seed would freeze the generator
    function automatic gen_vec_t seed_fix(input gen_vec_t s);
        return (s == '0) ? gen_vec_t'(1) : s;
    endfunction

    function automatic wterm_t make_terms(input logic [WSRC_W-1:0] g);
        wterm_t t;
        t.half      = g[0];
        t.quarter   = &g[2:1];
        t.eighth    = &g[5:3];
        t.sixteenth = &g[9:6];
        return t;
    endfunction

    function automatic logic pick_weight(input wterm_t t, input code_t c);
        return (c[3] & t.half) | (c[2] & t.quarter) |
               (c[1] & t.eighth) | (c[0] & t.sixteenth);
    endfunction

    // tap triple of phase-shifter output j
    function automatic int tap_a(input int j);
        return j;
    endfunction

    function automatic int tap_b(input int j);
        return j + GEN_W / 2;
    endfunction

    function automatic int tap_c(input int j);
        return (7 * j + 3) % GEN_W;
    endfunction

endpackage

// File: rtl/lpwpg_gen.sv
module lpwpg_gen
    import lpwpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gen_vec_t seed,
    output gen_vec_t state
);

    gen_vec_t state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= seed_fix(seed);
        else     state_q <= gen_step(state_q);
    end

    assign state = state_q;

endmodule

// File: rtl/lpwpg_weight.sv
module lpwpg_weight
    import lpwpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pat_start,
    input  code_t             code,
    input  logic [WSRC_W-1:0] gsrc,
    output gen_vec_t          aux,
    output gen_vec_t          ctrl
);

    wterm_t   terms;
    logic     wbit;
    gen_vec_t aux_q;
    gen_vec_t ctrl_q;

    always_comb begin
        terms = make_terms(gsrc);
        wbit  = pick_weight(terms, code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_q  <= '0;
            ctrl_q <= '1;
        end else begin
            aux_q <= {aux_q[GEN_W-2:0], wbit};
            if (pat_start) ctrl_q <= aux_q;
        end
    end

    assign aux  = aux_q;
    assign ctrl = ctrl_q;

endmodule

// File: rtl/lpwpg_hold.sv
module lpwpg_hold
    import lpwpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bypass,
    input  gen_vec_t ctrl,
    input  gen_vec_t gen,
    output gen_vec_t hold
);

    gen_vec_t hold_q;

    for (genvar i = 0; i < GEN_W; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)                       hold_q[i] <= 1'b0;
            else if (bypass || ctrl[i])    hold_q[i] <= gen[i];
        end
    end

    assign hold = hold_q;

endmodule

// File: rtl/lpwpg_shifter.sv
module lpwpg_shifter
    import lpwpg_pkg::*;
(
    input  gen_vec_t              hold,
    output logic [N_CHAINS-1:0]   chains
);

    for (genvar j = 0; j < N_CHAINS; j++) begin : g_out
        localparam int TA = tap_a(j);
        localparam int TB = tap_b(j);
        localparam int TC = tap_c(j);
        assign chains[j] = hold[TA] ^ hold[TB] ^ hold[TC];
    end

endmodule

// File: rtl/lpwpg_top.sv
module lpwpg_top
    import lpwpg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                pat_start,
    input  logic [3:0]          sw_code,
    input  logic [31:0]         seed,
    output logic [15:0]         scan_in
);

    gen_vec_t gen_q;
    gen_vec_t aux_q;
    gen_vec_t ctrl_q;
    gen_vec_t hold_q;
    logic     lp_off;

    assign lp_off = (sw_code == '0);

    lpwpg_gen u_gen (
        .clk   (clk),
        .rst   (rst),
        .seed  (seed),
        .state (gen_q)
    );

    lpwpg_weight u_weight (
        .clk       (clk),
        .rst       (rst),
        .pat_start (pat_start),
        .code      (sw_code),
        .gsrc      (gen_q[WSRC_W-1:0]),
        .aux       (aux_q),
        .ctrl      (ctrl_q)
    );

    lpwpg_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .bypass (lp_off),
        .ctrl   (ctrl_q),
        .gen    (gen_q),
        .hold   (hold_q)
    );

    lpwpg_shifter u_shift (
        .hold   (hold_q),
        .chains (scan_in)
    );

endmodule

// File: rtl/lpwpg_chk.sv
module lpwpg_chk
    import lpwpg_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     pat_start,
    input code_t    sw_code,
    input gen_vec_t gen_q,
    input gen_vec_t aux_q,
    input gen_vec_t ctrl_q,
    input gen_vec_t hold_q
);

    // R9
    gen_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        gen_q != '0);

    // R5
    aux_shift_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> aux_q[GEN_W-1:1] == $past(aux_q[GEN_W-2:0]));

    // R6
    ctrl_reload_chk: assert property (@(posedge clk) disable iff (rst)
        pat_start |=> ctrl_q == $past(aux_q));

    // R6
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !pat_start |=> $stable(ctrl_q));

    // R7
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_code != '0) |=> ((hold_q ^ $past(hold_q)) & ~$past(ctrl_q)) == '0);

    // R8
    bypass_track_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_code == '0) |=> hold_q == $past(gen_q));

endmodule

bind lpwpg_top lpwpg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pat_start (pat_start),
    .sw_code   (sw_code),
    .gen_q     (gen_q),
    .aux_q     (aux_q),
    .ctrl_q    (ctrl_q),
    .hold_q    (hold_q)
);

// File: tb/lpwpg_top_bench.sv
`timescale 1ns/1ps
module lpwpg_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pat_start = 1'b0;
    logic [3:0]  sw_code = 4'd0;
    logic [31:0] seed = 32'h1234_5678;
    logic [15:0] scan_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference state
    logic [31:0] m_g, m_aux, m_ctrl, m_h;

    always #2.5 clk = ~clk;

    lpwpg_top u_lpwpg_top (
        .clk       (clk),
        .rst       (rst),
        .pat_start (pat_start),
        .sw_code   (sw_code),
        .seed      (seed),
        .scan_in   (scan_in)
    );

    function automatic logic [15:0] ref_scan(input logic [31:0] h);
        logic [15:0] r;
        for (int j = 0; j < 16; j++)
            r[j] = h[j] ^ h[j + 16] ^ h[(7 * j + 3) % 32];
        return r;
    endfunction

    function automatic logic ref_w(input logic [31:0] g, input logic [3:0] c);
        logic t1, t2, t3, t4;
        t1 = g[0];
        t2 = g[1] & g[2];
        t3 = g[3] & g[4] & g[5];
        t4 = g[6] & g[7] & g[8] & g[9];
        return (c[3] & t1) | (c[2] & t2) | (c[1] & t3) | (c[0] & t4);
    endfunction

    task automatic check(input string tag);
        logic [15:0] exp;
        exp = ref_scan(m_h);
        n_checks++;
        if (scan_in !== exp) begin
            n_fail++;
            $display("FAIL %s: scan_in=%h expected=%h", tag, scan_in, exp);
        end
    endtask

    // drive inputs at negedge, advance model, compare at next negedge
    task automatic cycle(input logic r, input logic ps, input logic [3:0] c,
                         input string tag);
        logic [31:0] en;
        rst = r; pat_start = ps; sw_code = c;
        if (r) begin
            m_g    = (seed == 0) ? 32'h1 : seed;
            m_h    = '0;
            m_ctrl = '1;
            m_aux  = '0;
        end else begin
            en     = (c == 4'd0) ? 32'hFFFF_FFFF : m_ctrl;
            m_h    = (m_h & ~en) | (m_g & en);
            if (ps) m_ctrl = m_aux;
            m_aux  = {m_aux[30:0], ref_w(m_g, c)};
            m_g    = {1'b0, m_g[31:1]} ^ (m_g[0] ? 32'h8020_0003 : 32'h0);
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 4'd5, "R1");

        // R2 R3: all stages transparent, outputs follow the generator
        for (int k = 0; k < 40; k++) cycle(1'b0, 1'b0, 4'd0, "R2 R3");

        // R4 R5 R6 R7: every code, 32-cycle patterns
        for (int c = 1; c < 16; c++)
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 32; k++)
                    cycle(1'b0, (k == 0), 4'(c), "R4 R5 R6 R7");

        // R6: irregular pattern starts reload a partly refreshed mask
        for (int k = 0; k < 120; k++)
            cycle(1'b0, ((k % 7) == 3) || ((k % 11) == 0), 4'(4 + (k % 3)), "R6");

        // R8: sparse mask in place, then code zero bypasses it
        for (int k = 0; k < 33; k++) cycle(1'b0, (k == 32), 4'd1, "R7");
        for (int k = 0; k < 40; k++) cycle(1'b0, 1'b0, 4'd0, "R8");

        // R9: zero seed
        seed = 32'h0;
        for (int k = 0; k < 2; k++) cycle(1'b1, 1'b0, 4'd0, "R9");
        for (int k = 0; k < 64; k++) cycle(1'b0, (k % 32) == 0, 4'd8, "R9");
        for (int k = 0; k < 40; k++) cycle(1'b0, 1'b0, 4'd0, "R9");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule